// File: doc/BRIEF.md
# Six-Channel DMA Transfer Scheduler

This block is the scheduling and address-generation core of a six-channel DMA engine. Each channel holds its own context: start and current read/write addresses, an element count per frame, a frame count per block, two signed step values (one used inside a frame, one used when a frame ends), an addressing mode for each side, a priority level and an auto-reload flag. A channel context is loaded in one cycle through a single load port, which also arms or disarms the channel.

Every clock cycle is one transfer slot. Among channels that are armed and currently requesting, the block grants exactly one: any requesting high-level channel beats every low-level channel, and inside a level the choice rotates, with a separate rotation pointer per level. For the granted channel it emits the read/write address pair and then advances both addresses and the counters. When a channel's last element of its last frame goes out, it raises a one-cycle completion pulse and either disarms or reloads its start context. Three of the completion pulses share CPU interrupt lines with other interrupt sources, chosen by a select input.

Top module: `dma_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `xfer_valid`, `ch_active`, `dma_done` are all zero and `cpu_irq` shows only the non-DMA sources routed onto shared lines.
- R2: A cycle with `cfg_we` high loads the whole context of channel `cfg_ch` and sets its armed state to `cfg_enable`; its first transfer presents exactly the loaded start addresses.
- R3: A channel is eligible when it is armed and its `req` bit is high; if any channel is eligible in a cycle, the next cycle shows `xfer_valid` high with the granted channel number on `xfer_ch` and that channel's current addresses, otherwise `xfer_valid` is low.
- R4: If any eligible channel has its priority bit set (1 = high), the grant goes to a high-priority channel.
- R5: Within a priority level the grant goes to the first eligible channel at or after that level's pointer, counting upward with wrap; after a grant only that level's pointer moves to the granted channel plus one (wrapping after channel 5). Both pointers start at channel 0.
- R6: Each side has a 2-bit mode: 0 leaves the address unchanged, 1 adds one, 2 subtracts one, 3 adds a signed step; the read side and write side use their own mode.
- R7: In mode 3 the element step is added after every transfer that is not the last of its frame, and the frame step is added after the last transfer of a frame.
- R8: After element count times frame count transfers the channel's `dma_done` bit pulses for one cycle, in the same cycle as that last transfer's output, and a channel without auto-reload drops its `ch_active` bit in that cycle.
- R9: A channel with auto-reload stays armed at block end and restarts from its loaded start addresses and full counts.
- R10: `cpu_irq` bits 0, 4 and 5 carry `dma_done` directly; bit 1 carries `dma_done[1]` when `irq_sel[0]`=1 else `tmr1_irq`, bit 2 carries `dma_done[2]` when `irq_sel[1]`=1 else `sp_rx_irq`, bit 3 carries `dma_done[3]` when `irq_sel[2]`=1 else `sp_tx_irq`.
- R11: Requests from channels that are not armed are ignored: they produce no transfer and move no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a channel context this cycle |
| cfg_ch | input | 3 | Channel being loaded |
| cfg_src | input | 16 | Start read address |
| cfg_dst | input | 16 | Start write address |
| cfg_elem_cnt | input | 8 | Elements per frame |
| cfg_frame_cnt | input | 8 | Frames per block |
| cfg_elem_idx | input | 16 | Signed step inside a frame |
| cfg_frame_idx | input | 16 | Signed step at frame end |
| cfg_src_mode | input | 2 | Read-side address mode |
| cfg_dst_mode | input | 2 | Write-side address mode |
| cfg_high_prio | input | 1 | 1 = high priority level |
| cfg_autoinit | input | 1 | Reload context at block end |
| cfg_enable | input | 1 | Arm the channel |
| req | input | 6 | Per-channel service request |
| irq_sel | input | 3 | Shared-line routing select |
| tmr1_irq | input | 1 | Timer source sharing line 1 |
| sp_rx_irq | input | 1 | Serial receive source sharing line 2 |
| sp_tx_irq | input | 1 | Serial transmit source sharing line 3 |
| xfer_valid | output | 1 | A transfer is issued |
| xfer_ch | output | 3 | Granted channel |
| xfer_rd_addr | output | 16 | Read address of the transfer |
| xfer_wr_addr | output | 16 | Write address of the transfer |
| ch_active | output | 6 | Armed state per channel |
| dma_done | output | 6 | Block-complete pulse per channel |
| cpu_irq | output | 6 | Routed interrupt lines |

## Verification
A request seen at a rising edge yields its transfer, its address pair and any completion pulse on the outputs right after that same edge, one cycle after the inputs were set; `ch_active` changes at the same edge, and `cpu_irq` follows `dma_done` and the shared sources with no further delay. The bench drives inputs on the falling edge, steps an arithmetic model of the requirements once for that cycle, and compares every output at the next falling edge, so each comparison falls exactly in the cycle its result is due.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_INC  = 2'd1,
    AM_DEC  = 2'd2,
    AM_IDX  = 2'd3
  } amode_e;
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH = 6,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] elig,
  input  logic [NCH-1:0] high,
  output logic           gnt_vld,
  output logic [IW-1:0]  gnt_idx
);
  logic [IW-1:0] ptr_hi_q, ptr_hi_d, ptr_lo_q, ptr_lo_d;
  logic [NCH-1:0] m_hi, m_lo;
  logic [IW:0] pk_hi, pk_lo;
  logic use_hi;
  logic [IW-1:0] nxt_idx;

  // first set bit of m at or after p, wrapping; MSB of result = found
  function automatic logic [IW:0] rr_pick(input logic [NCH-1:0] m, input logic [IW-1:0] p);
    logic [IW:0] r;
    r = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      int j;
      j = (int'(p) + k) % NCH;
      if (m[j]) r = {1'b1, IW'(j)};
    end
    return r;
  endfunction

  always_comb begin
    m_hi    = elig & high;
    m_lo    = elig & ~high;
    pk_hi   = rr_pick(m_hi, ptr_hi_q);
    pk_lo   = rr_pick(m_lo, ptr_lo_q);
    use_hi  = |m_hi;
    gnt_vld = |elig;
    gnt_idx = use_hi ? pk_hi[IW-1:0] : pk_lo[IW-1:0];
    nxt_idx = (int'(gnt_idx) == NCH - 1) ? '0 : gnt_idx + 1'b1;
    ptr_hi_d = ptr_hi_q;
    ptr_lo_d = ptr_lo_q;
    if (gnt_vld && use_hi)  ptr_hi_d = nxt_idx;
    if (gnt_vld && !use_hi) ptr_lo_d = nxt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_hi_q <= '0;
      ptr_lo_q <= '0;
    end else if (gnt_vld) begin
      ptr_hi_q <= ptr_hi_d;
      ptr_lo_q <= ptr_lo_d;
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_sched_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_ecnt,
  input  logic [CW-1:0] ld_fcnt,
  input  logic [AW-1:0] ld_eidx,
  input  logic [AW-1:0] ld_fidx,
  input  amode_e        ld_smode,
  input  amode_e        ld_dmode,
  input  logic          ld_prio,
  input  logic          ld_auto,
  input  logic          ld_en,
  input  logic          gnt,
  output logic          active,
  output logic          prio,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          done
);
  // loaded start context
  logic [AW-1:0] src0_q, dst0_q, eidx_q, fidx_q;
  logic [CW-1:0] ecnt0_q, fcnt0_q;
  amode_e        sm_q, dm_q;
  logic          prio_q, auto_q;
  // running context
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] el_q, el_d, fl_q, fl_d;
  logic          act_q, act_d, done_q, done_d;
  logic          last_e, last_b;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input amode_e m,
                                         input logic [AW-1:0] stp);
    case (m)
      AM_INC:  return a + 1'b1;
      AM_DEC:  return a - 1'b1;
      AM_IDX:  return a + stp;
      default: return a;
    endcase
  endfunction

  always_comb begin
    // a count of zero behaves like one
    last_e = (el_q <= CW'(1));
    last_b = last_e && (fl_q <= CW'(1));
    src_d  = src_q;
    dst_d  = dst_q;
    el_d   = el_q;
    fl_d   = fl_q;
    act_d  = act_q;
    done_d = 1'b0;
    if (gnt) begin
      src_d = step(src_q, sm_q, last_e ? fidx_q : eidx_q);
      dst_d = step(dst_q, dm_q, last_e ? fidx_q : eidx_q);
      if (last_e) begin
        el_d = ecnt0_q;
        fl_d = fl_q - 1'b1;
      end else begin
        el_d = el_q - 1'b1;
      end
      if (last_b) begin
        done_d = 1'b1;
        if (auto_q) begin
          src_d = src0_q;
          dst_d = dst0_q;
          fl_d  = fcnt0_q;
        end else begin
          act_d = 1'b0;
        end
      end
    end
    if (ld) begin
      src_d = ld_src;
      dst_d = ld_dst;
      el_d  = ld_ecnt;
      fl_d  = ld_fcnt;
      act_d = ld_en;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      src0_q  <= ld_src;
      dst0_q  <= ld_dst;
      ecnt0_q <= ld_ecnt;
      fcnt0_q <= ld_fcnt;
      eidx_q  <= ld_eidx;
      fidx_q  <= ld_fidx;
      sm_q    <= ld_smode;
      dm_q    <= ld_dmode;
      auto_q  <= ld_auto;
    end
    if (ld || gnt) begin
      src_q <= src_d;
      dst_q <= dst_d;
      el_q  <= el_d;
      fl_q  <= fl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      prio_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      if (ld) prio_q <= ld_prio;
    end
  end

  assign active = act_q;
  assign prio   = prio_q;
  assign src    = src_q;
  assign dst    = dst_q;
  assign done   = done_q;
endmodule

// File: rtl/dma_irq_route.sv
module dma_irq_route #(
  parameter int NCH = 6
) (
  input  logic [NCH-1:0] done,
  input  logic [2:0]     sel,
  input  logic [2:0]     other,
  output logic [NCH-1:0] irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_line
    if (i >= 1 && i <= 3) begin : g_shared
      assign irq[i] = sel[i-1] ? done[i] : other[i-1];
    end else begin : g_own
      assign irq[i] = done[i];
    end
  end
endmodule

// File: rtl/dma_sched.sv
module dma_sched
  import dma_sched_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 16,
  parameter int CW  = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_elem_cnt,
  input  logic [CW-1:0]  cfg_frame_cnt,
  input  logic [AW-1:0]  cfg_elem_idx,
  input  logic [AW-1:0]  cfg_frame_idx,
  input  logic [1:0]     cfg_src_mode,
  input  logic [1:0]     cfg_dst_mode,
  input  logic           cfg_high_prio,
  input  logic           cfg_autoinit,
  input  logic           cfg_enable,
  input  logic [NCH-1:0] req,
  input  logic [2:0]     irq_sel,
  input  logic           tmr1_irq,
  input  logic           sp_rx_irq,
  input  logic           sp_tx_irq,
  output logic           xfer_valid,
  output logic [IW-1:0]  xfer_ch,
  output logic [AW-1:0]  xfer_rd_addr,
  output logic [AW-1:0]  xfer_wr_addr,
  output logic [NCH-1:0] ch_active,
  output logic [NCH-1:0] dma_done,
  output logic [NCH-1:0] cpu_irq
);
  logic [NCH-1:0] act_w, prio_w, done_w, elig_w, gnt_oh;
  logic [AW-1:0]  src_w [NCH];
  logic [AW-1:0]  dst_w [NCH];
  logic           gnt_vld;
  logic [IW-1:0]  gnt_idx;
  logic           vld_q;
  logic [IW-1:0]  ch_q;
  logic [AW-1:0]  rd_q, wr_q;

  assign elig_w = act_w & req;

  dma_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig_w), .high(prio_w),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign gnt_oh[c] = gnt_vld && (int'(gnt_idx) == c);
    dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .ld(cfg_we && (int'(cfg_ch) == c)),
      .ld_src(cfg_src), .ld_dst(cfg_dst),
      .ld_ecnt(cfg_elem_cnt), .ld_fcnt(cfg_frame_cnt),
      .ld_eidx(cfg_elem_idx), .ld_fidx(cfg_frame_idx),
      .ld_smode(amode_e'(cfg_src_mode)), .ld_dmode(amode_e'(cfg_dst_mode)),
      .ld_prio(cfg_high_prio), .ld_auto(cfg_autoinit), .ld_en(cfg_enable),
      .gnt(gnt_oh[c]),
      .active(act_w[c]), .prio(prio_w[c]),
      .src(src_w[c]), .dst(dst_w[c]), .done(done_w[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= gnt_vld;
  end

  always_ff @(posedge clk) begin
    if (gnt_vld) begin
      ch_q <= gnt_idx;
      rd_q <= src_w[gnt_idx];
      wr_q <= dst_w[gnt_idx];
    end
  end

  dma_irq_route #(.NCH(NCH)) u_irq (
    .done(done_w), .sel(irq_sel),
    .other({sp_tx_irq, sp_rx_irq, tmr1_irq}), .irq(cpu_irq)
  );

  assign xfer_valid   = vld_q;
  assign xfer_ch      = ch_q;
  assign xfer_rd_addr = rd_q;
  assign xfer_wr_addr = wr_q;
  assign ch_active    = act_w;
  assign dma_done     = done_w;
endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
  parameter int NCH = 6,
  localparam int IW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] elig,
  input logic [NCH-1:0] prio,
  input logic           xfer_valid,
  input logic [IW-1:0]  xfer_ch,
  input logic [NCH-1:0] dma_done
);
  logic [NCH-1:0] elig_q, prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q <= '0;
      prio_q <= '0;
    end else begin
      elig_q <= elig;
      prio_q <= prio;
    end
  end

  assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> elig_q[xfer_ch]);

  assert_idle_without_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|elig) |=> !xfer_valid);

  assert_serve_when_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |=> xfer_valid);

  assert_high_level_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && (|(elig_q & prio_q))) |-> prio_q[xfer_ch]);

  assert_done_with_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_done) |-> (xfer_valid && dma_done[xfer_ch]));

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_done));
endmodule

bind dma_sched dma_sched_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .elig(elig_w), .prio(prio_w),
  .xfer_valid(xfer_valid), .xfer_ch(xfer_ch), .dma_done(dma_done)
);

// File: tb/tb_dma_sched.sv
module tb_dma_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_ch;
  logic [15:0] cfg_src, cfg_dst, cfg_elem_idx, cfg_frame_idx;
  logic [7:0]  cfg_elem_cnt, cfg_frame_cnt;
  logic [1:0]  cfg_src_mode, cfg_dst_mode;
  logic        cfg_high_prio, cfg_autoinit, cfg_enable;
  logic [5:0]  req;
  logic [2:0]  irq_sel;
  logic        tmr1_irq, sp_rx_irq, sp_tx_irq;
  logic        xfer_valid;
  logic [2:0]  xfer_ch;
  logic [15:0] xfer_rd_addr, xfer_wr_addr;
  logic [5:0]  ch_active, dma_done, cpu_irq;

  always #5 clk = ~clk;

  dma_sched dut (.*);

  int nvec = 0;
  int nbad = 0;
  bit finished = 0;

  // reference state
  logic [15:0] m_src0[6], m_dst0[6], m_eidx[6], m_fidx[6], m_src[6], m_dst[6];
  int          m_ecnt[6], m_fcnt[6], m_el[6], m_fl[6];
  logic [1:0]  m_sm[6], m_dm[6];
  logic [5:0]  m_prio, m_auto, m_act;
  int          p_hi, p_lo;
  logic        e_valid;
  logic [2:0]  e_ch;
  logic [15:0] e_rd, e_wr;
  logic [5:0]  e_done;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mstep(input logic [15:0] a, input logic [1:0] m, input logic [15:0] s);
    case (m)
      2'd1: return a + 16'd1;
      2'd2: return a - 16'd1;
      2'd3: return a + s;
      default: return a;
    endcase
  endfunction

  // one cycle of the requirement model, from the inputs now applied
  task automatic model_step();
    logic [5:0] el, mk;
    bit use_hi, found;
    int g, ptr;
    el = m_act & req;
    use_hi = |(el & m_prio);
    mk = use_hi ? (el & m_prio) : (el & ~m_prio);
    ptr = use_hi ? p_hi : p_lo;
    found = 0; g = 0;
    for (int k = 0; k < 6; k++) begin
      int j = (ptr + k) % 6;
      if (!found && mk[j]) begin found = 1; g = j; end
    end
    e_done = '0;
    e_valid = found;
    if (found) begin
      bit le;
      e_ch = 3'(g); e_rd = m_src[g]; e_wr = m_dst[g];
      le = (m_el[g] <= 1);
      m_src[g] = mstep(m_src[g], m_sm[g], le ? m_fidx[g] : m_eidx[g]);
      m_dst[g] = mstep(m_dst[g], m_dm[g], le ? m_fidx[g] : m_eidx[g]);
      if (le && m_fl[g] <= 1) begin
        e_done[g] = 1'b1;
        if (m_auto[g]) begin
          m_src[g] = m_src0[g]; m_dst[g] = m_dst0[g]; m_fl[g] = m_fcnt[g]; m_el[g] = m_ecnt[g];
        end else m_act[g] = 1'b0;
      end else if (le) begin
        m_el[g] = m_ecnt[g]; m_fl[g] = m_fl[g] - 1;
      end else m_el[g] = m_el[g] - 1;
      if (use_hi) p_hi = (g + 1) % 6; else p_lo = (g + 1) % 6;
    end
    if (cfg_we) begin
      int c = int'(cfg_ch);
      m_src0[c] = cfg_src; m_dst0[c] = cfg_dst; m_src[c] = cfg_src; m_dst[c] = cfg_dst;
      m_ecnt[c] = cfg_elem_cnt; m_fcnt[c] = cfg_frame_cnt; m_el[c] = cfg_elem_cnt; m_fl[c] = cfg_frame_cnt;
      m_eidx[c] = cfg_elem_idx; m_fidx[c] = cfg_frame_idx; m_sm[c] = cfg_src_mode; m_dm[c] = cfg_dst_mode;
      m_prio[c] = cfg_high_prio; m_auto[c] = cfg_autoinit; m_act[c] = cfg_enable;
    end
  endtask

  function automatic logic [5:0] exp_irq();
    logic [5:0] r;
    r = e_done;
    r[1] = irq_sel[0] ? e_done[1] : tmr1_irq;
    r[2] = irq_sel[1] ? e_done[2] : sp_rx_irq;
    r[3] = irq_sel[2] ? e_done[3] : sp_tx_irq;
    return r;
  endfunction

  int nxfer = 0;
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(xfer_valid == e_valid, "R3 R11 valid", 32'(xfer_valid), 32'(e_valid));
    if (e_valid) begin
      chk(xfer_ch == e_ch, "R4 R5 channel", 32'(xfer_ch), 32'(e_ch));
      chk(xfer_rd_addr == e_rd, "R2 R6 R7 R9 read address", 32'(xfer_rd_addr), 32'(e_rd));
      chk(xfer_wr_addr == e_wr, "R2 R6 R7 R9 write address", 32'(xfer_wr_addr), 32'(e_wr));
    end
    if (xfer_valid) nxfer++;
    chk(dma_done == e_done, "R8 done", 32'(dma_done), 32'(e_done));
    chk(ch_active == m_act, "R2 R8 R9 active", 32'(ch_active), 32'(m_act));
    chk(cpu_irq == exp_irq(), "R10 irq", 32'(cpu_irq), 32'(exp_irq()));
    cfg_we = 1'b0;
  endtask

  task automatic load(input int c, input logic [15:0] s, input logic [15:0] d, input int ec, input int fc,
                      input logic [15:0] ei, input logic [15:0] fi, input logic [1:0] sm, input logic [1:0] dm,
                      input bit hp, input bit au, input bit en);
    req = '0;
    cfg_we = 1'b1; cfg_ch = 3'(c); cfg_src = s; cfg_dst = d;
    cfg_elem_cnt = 8'(ec); cfg_frame_cnt = 8'(fc); cfg_elem_idx = ei; cfg_frame_idx = fi;
    cfg_src_mode = sm; cfg_dst_mode = dm; cfg_high_prio = hp; cfg_autoinit = au; cfg_enable = en;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [5:0] pm[4];
    pm[0] = 6'h00; pm[1] = 6'h3F; pm[2] = 6'h15; pm[3] = 6'h32;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_src = '0; cfg_dst = '0;
    cfg_elem_cnt = '0; cfg_frame_cnt = '0; cfg_elem_idx = '0; cfg_frame_idx = '0;
    cfg_src_mode = '0; cfg_dst_mode = '0; cfg_high_prio = 0; cfg_autoinit = 0; cfg_enable = 0;
    req = '0; irq_sel = 3'b111; tmr1_irq = 0; sp_rx_irq = 0; sp_tx_irq = 0;
    m_prio = '0; m_auto = '0; m_act = '0; p_hi = 0; p_lo = 0; e_valid = 0; e_done = '0;
    e_ch = '0; e_rd = '0; e_wr = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held quiet in reset
    chk(xfer_valid == 1'b0, "R1 valid in reset", 32'(xfer_valid), 0);
    chk(ch_active == 6'h0, "R1 active in reset", 32'(ch_active), 0);
    chk(cpu_irq == 6'h0, "R1 irq in reset", 32'(cpu_irq), 0);
    rst_n = 1'b1;
    // R11: requests with nothing armed
    req = 6'h3F; cyc();
    // sweep priority layouts, all request patterns, all routing selects
    for (int ps = 0; ps < 4; ps++) begin
      for (int c = 0; c < 6; c++)
        load(c, 16'(c * 16'h1000 + ps), 16'(16'h8000 + c * 16'h100), 2 + c % 3, 3 + c,
             16'(c + 1), 16'(16'hFFF0 + c), 2'((c + ps) % 4), 2'((c + 2) % 4),
             pm[ps][c], c % 2 == 1, 1'b1);
      for (int r = 0; r < 64; r++) begin
        irq_sel = 3'(r >> 3);
        {tmr1_irq, sp_rx_irq, sp_tx_irq} = 3'(r) ^ 3'(ps);
        for (int t = 0; t < 3; t++) begin req = 6'(r); cyc(); end
      end
    end
    // R8: 2x2 block without reload ends after four transfers; R7 steps
    for (int c = 0; c < 6; c++) load(c, 16'h0, 16'h0, 1, 1, 0, 0, 0, 0, 0, 0, 1'b0);
    load(4, 16'h0100, 16'h0200, 2, 2, 16'h0004, 16'hFFF8, 2'd3, 2'd3, 1'b0, 1'b0, 1'b1);
    nxfer = 0;
    irq_sel = 3'b111;
    for (int t = 0; t < 8; t++) begin req = 6'h10; cyc(); end
    chk(nxfer == 4, "R8 transfer count per block", 32'(nxfer), 4);
    // R9: reload keeps channel 2 running
    load(2, 16'h0500, 16'h0600, 1, 2, 0, 0, 2'd1, 2'd2, 1'b1, 1'b1, 1'b1);
    for (int t = 0; t < 7; t++) begin req = 6'h04; cyc(); end
    req = '0; cyc();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule